// File: doc/BRIEF.md
# Split Address Output Latch with Snoop Capture

This block sits between a cache controller's internal cycle logic and a shared memory address bus. A 30-bit address is held in an output register split into two independently controlled portions: a sub-line portion (the 7 low bits) and a line portion (the 11-bit set and 12-bit tag fields). Each portion has its own latch enable. While that enable is high, a new internal cycle address passes into the portion. While it is low, the portion holds the address it already has. Each portion also has its own active-low output enable, which drives a per-bit tri-state enable vector for the pads.

When both output enables are inactive, the bus pins act as inputs. A snoop-start strobe then samples the full 30-bit address from the pins into a snoop-address register. If a snoop starts while either portion is driving the bus, the capture is refused and a one-cycle protocol-error pulse is raised. A bus-start strobe marks the cycle in which a freshly loaded address first appears on a fully enabled bus.

Top module: `addr_xlatch_top`

## Requirements
- R1: After a clock edge with `rst_n` low, `pin_out`, `snp_addr`, `snp_err` and `bus_start` are all zero.
- R2: At a clock edge where `cyc_valid` and `sub_le` are both high, `pin_out[6:0]` takes `cyc_addr[6:0]`, and the new value is visible after that edge.
- R3: At a clock edge where `cyc_valid` and `line_le` are both high, `pin_out[29:7]` takes `cyc_addr[29:7]`. The set field is bits 17:7 and the tag field is bits 29:18.
- R4: A portion whose latch enable is low at a clock edge keeps its previous value, whatever `cyc_valid` and `cyc_addr` are doing.
- R5: With `cyc_valid` low, neither portion changes, even when its latch enable is high.
- R6: `pin_oe[6:0]` are all equal to `!sub_oe_n`, and `pin_oe[29:7]` are all equal to `!line_oe_n`. These follow the enable inputs within the same cycle.
- R7: `bus_start` is high for exactly the cycle after an edge where `cyc_valid`, `sub_le` and `line_le` are high and `sub_oe_n` and `line_oe_n` are low. It is low after every other edge.
- R8: At an edge with `snp_start` high and both output enables inactive (high), `snp_addr` takes `pin_in` and `snp_err` is low after that edge.
- R9: At an edge with `snp_start` high and either output enable active (low), `snp_addr` keeps its value and `snp_err` is high for the following cycle only. `snp_err` is low after any edge without `snp_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | New internal cycle address is valid |
| cyc_addr | input | 30 | Internal cycle address (tag 29:18, set 17:7, low 6:0) |
| sub_le | input | 1 | Sub-line portion latch enable, high = transparent |
| line_le | input | 1 | Line portion latch enable, high = transparent |
| sub_oe_n | input | 1 | Sub-line portion output enable, active low |
| line_oe_n | input | 1 | Line portion output enable, active low |
| snp_start | input | 1 | Snoop initiation strobe |
| pin_in | input | 30 | Address sensed on the bus pins |
| pin_out | output | 30 | Latched address to drive onto the pins |
| pin_oe | output | 30 | Per-bit pad drive enable |
| bus_start | output | 1 | Address first on a fully enabled bus this cycle |
| snp_addr | output | 30 | Captured snoop address |
| snp_err | output | 1 | Snoop started while a portion was driving |

## Verification
If a portion's held register were corrupted or loaded at the wrong time, the fault shows on the matching `pin_out` bits one cycle after the offending edge, with no further delay. A wrong snoop-accept decision shows after a single edge, either as a changed `snp_addr` together with a missing `snp_err` pulse, or the other way round. The sweep covers every combination of the two latch enables, the two output enables and `cyc_valid`, so that a crossed portion mapping or a swapped enable polarity is exposed at the ports straight away.

// File: rtl/addr_xlatch_pkg.sv
// Package: field widths of the split address and helpers shared by the
// latch block, its checker and its bench. Assumes the low field sits at
// the bottom, then set, then tag, with no gaps.
package addr_xlatch_pkg;
    localparam int LOW_W  = 7;
    localparam int SET_W  = 11;
    localparam int TAG_W  = 12;
    localparam int ADDR_W = LOW_W + SET_W + TAG_W;
    localparam int SUB_W  = LOW_W;
    localparam int LINE_W = SET_W + TAG_W;

    typedef enum logic [1:0] {
        SNP_IDLE   = 2'b00,
        SNP_ACCEPT = 2'b01,
        SNP_REJECT = 2'b10
    } snp_decision_e;

    // Decide what a snoop strobe does given the two active-low enables.
    function automatic snp_decision_e snoop_decide(input logic start,
                                                   input logic sub_oe_n,
                                                   input logic line_oe_n);
        if (!start)
            return SNP_IDLE;
        else if (sub_oe_n && line_oe_n)
            return SNP_ACCEPT;
        else
            return SNP_REJECT;
    endfunction
endpackage

// File: rtl/xlatch_slice.sv
// Module: one portion of the split address output latch.
// Behaves as a hold register: it loads d on a clock edge where load_en
// is high and otherwise keeps its value. The held value is always shown
// on q. The pad drive enables are replicated from the active-low output
// enable. Assumes a synchronous active-low reset that clears the held value.
module xlatch_slice #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] d,
    input  logic         oe_n,
    output logic [W-1:0] q,
    output logic [W-1:0] drv_en
);
    logic [W-1:0] held_q;

    // Hold register: transparent-on-clock load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (load_en)
            held_q <= d;
    end

    // Per-bit pad drive enable from the portion's active-low enable.
    always_comb begin
        for (int i = 0; i < W; i++)
            drv_en[i] = ~oe_n;
    end

    assign q = held_q;
endmodule

// File: rtl/snoop_sampler.sv
// Module: samples the bus pins into the snoop-address register.
// A strobe is accepted only when both portions are off the bus. A strobe
// that arrives while either portion is driving leaves the register
// untouched and gives a one-cycle error pulse. Assumes a synchronous
// active-low reset.
module snoop_sampler #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sub_oe_n,
    input  logic         line_oe_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] addr_q,
    output logic         err_q
);
    import addr_xlatch_pkg::*;

    snp_decision_e decision;

    // Classify the strobe in this cycle.
    always_comb decision = snoop_decide(start, sub_oe_n, line_oe_n);

    // Capture the address register on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (decision == SNP_ACCEPT)
            addr_q <= pins;
    end

    // Pulse the error flag for one cycle on a rejected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= (decision == SNP_REJECT);
    end
endmodule

// File: rtl/addr_xlatch_top.sv
// Module: split address output latch with snoop capture.
// The sub-line portion carries the low field and the line portion carries
// the set and tag fields. Each portion loads from the new-cycle address
// only while its own latch enable is high and the cycle is valid. The
// pins are inputs whenever both enables are inactive, and a snoop strobe
// samples them then. Assumes synchronous active-low reset and that the
// pad logic combines pin_out and pin_oe.
module addr_xlatch_top
    import addr_xlatch_pkg::*;
#(
    parameter int P_LOW_W = LOW_W,
    parameter int P_SET_W = SET_W,
    parameter int P_TAG_W = TAG_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cyc_valid,
    input  logic [P_LOW_W+P_SET_W+P_TAG_W-1:0]   cyc_addr,
    input  logic                                 sub_le,
    input  logic                                 line_le,
    input  logic                                 sub_oe_n,
    input  logic                                 line_oe_n,
    input  logic                                 snp_start,
    input  logic [P_LOW_W+P_SET_W+P_TAG_W-1:0]   pin_in,
    output logic [P_LOW_W+P_SET_W+P_TAG_W-1:0]   pin_out,
    output logic [P_LOW_W+P_SET_W+P_TAG_W-1:0]   pin_oe,
    output logic                                 bus_start,
    output logic [P_LOW_W+P_SET_W+P_TAG_W-1:0]   snp_addr,
    output logic                                 snp_err
);
    localparam int AW  = P_LOW_W + P_SET_W + P_TAG_W;
    localparam int SW  = P_LOW_W;
    localparam int LW  = P_SET_W + P_TAG_W;

    logic          sub_load;
    logic          line_load;
    logic          full_drive;
    logic [SW-1:0] sub_q;
    logic [SW-1:0] sub_drv;
    logic [LW-1:0] line_q;
    logic [LW-1:0] line_drv;
    logic          start_q;

    // Load qualifiers for each portion.
    always_comb begin
        sub_load   = cyc_valid & sub_le;
        line_load  = cyc_valid & line_le;
        full_drive = sub_load & line_load & ~sub_oe_n & ~line_oe_n;
    end

    xlatch_slice #(.W(SW)) sub_slice_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (sub_load),
        .d       (cyc_addr[SW-1:0]),
        .oe_n    (sub_oe_n),
        .q       (sub_q),
        .drv_en  (sub_drv)
    );

    xlatch_slice #(.W(LW)) line_slice_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (line_load),
        .d       (cyc_addr[AW-1:SW]),
        .oe_n    (line_oe_n),
        .q       (line_q),
        .drv_en  (line_drv)
    );

    snoop_sampler #(.W(AW)) snoop_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (snp_start),
        .sub_oe_n  (sub_oe_n),
        .line_oe_n (line_oe_n),
        .pins      (pin_in),
        .addr_q    (snp_addr),
        .err_q     (snp_err)
    );

    // Mark the cycle in which a new address first shows on a fully driven bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= 1'b0;
        else
            start_q <= full_drive;
    end

    assign pin_out   = {line_q, sub_q};
    assign pin_oe    = {line_drv, sub_drv};
    assign bus_start = start_q;
endmodule

// File: rtl/addr_xlatch_chk.sv
// Checker: temporal properties of the split address latch, observed at
// its ports. Bound to every instance of addr_xlatch_top.
module addr_xlatch_chk #(
    parameter int AW = 30,
    parameter int SW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_valid,
    input logic [AW-1:0] cyc_addr,
    input logic          sub_le,
    input logic          line_le,
    input logic          sub_oe_n,
    input logic          line_oe_n,
    input logic          snp_start,
    input logic [AW-1:0] pin_in,
    input logic [AW-1:0] pin_out,
    input logic [AW-1:0] pin_oe,
    input logic          bus_start,
    input logic [AW-1:0] snp_addr,
    input logic          snp_err
);
    a_r2_sub_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && sub_le) |=> (pin_out[SW-1:0] == $past(cyc_addr[SW-1:0])));

    a_r3_line_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && line_le) |=> (pin_out[AW-1:SW] == $past(cyc_addr[AW-1:SW])));

    a_r4_sub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_le || !cyc_valid) |=> $stable(pin_out[SW-1:0]));

    a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_le || !cyc_valid) |=> $stable(pin_out[AW-1:SW]));

    a_r6_sub_drive: assert property (@(posedge clk) disable iff (!rst_n)
        sub_oe_n |-> (pin_oe[SW-1:0] == '0));

    a_r6_line_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe_n |-> (pin_oe[AW-1:SW] == '1));

    a_r7_bus_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && sub_le && line_le && !sub_oe_n && !line_oe_n) |=> bus_start);

    a_r8_snoop_take: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_start && sub_oe_n && line_oe_n) |=> (snp_addr == $past(pin_in) && !snp_err));

    a_r9_snoop_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_start && !(sub_oe_n && line_oe_n)) |=> (snp_err && $stable(snp_addr)));

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_start |=> !snp_err);
endmodule

bind addr_xlatch_top addr_xlatch_chk #(.AW(AW), .SW(SW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .sub_le    (sub_le),
    .line_le   (line_le),
    .sub_oe_n  (sub_oe_n),
    .line_oe_n (line_oe_n),
    .snp_start (snp_start),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .bus_start (bus_start),
    .snp_addr  (snp_addr),
    .snp_err   (snp_err)
);

// File: tb/addr_xlatch_top_tb.sv
// Bench: sweeps every combination of the latch enables, output enables
// and cycle valid, then every output-enable combination for snoops.
// Expected values come from a small arithmetic model of the requirements.
module addr_xlatch_top_tb_top;
    localparam int AW = 30;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_valid = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic          sub_le = 1'b0;
    logic          line_le = 1'b0;
    logic          sub_oe_n = 1'b1;
    logic          line_oe_n = 1'b1;
    logic          snp_start = 1'b0;
    logic [AW-1:0] pin_in = '0;
    logic [AW-1:0] pin_out;
    logic [AW-1:0] pin_oe;
    logic          bus_start;
    logic [AW-1:0] snp_addr;
    logic          snp_err;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    addr_xlatch_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .cyc_addr  (cyc_addr),
        .sub_le    (sub_le),
        .line_le   (line_le),
        .sub_oe_n  (sub_oe_n),
        .line_oe_n (line_oe_n),
        .snp_start (snp_start),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .bus_start (bus_start),
        .snp_addr  (snp_addr),
        .snp_err   (snp_err)
    );

    task automatic check(input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk_addr(input int k);
        return AW'((k * 32'h0003_ACE1 + 32'h1234_5671) ^ (k << 19));
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] exp_pin;
        logic [AW-1:0] exp_snp;
        logic [AW-1:0] exp_oe;
        logic          exp_bs;

        // R1: reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 pin_out", pin_out, '0);
        check("R1 snp_addr", snp_addr, '0);
        check("R1 snp_err", AW'(snp_err), '0);
        check("R1 bus_start", AW'(bus_start), '0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_pin = '0;
        exp_snp = '0;

        // R2..R7: full sweep, repeated with different addresses
        for (int pass = 0; pass < 3; pass++) begin
            for (int combo = 0; combo < 32; combo++) begin
                @(negedge clk);
                cyc_valid = combo[0];
                sub_le    = combo[1];
                line_le   = combo[2];
                sub_oe_n  = combo[3];
                line_oe_n = combo[4];
                cyc_addr  = mk_addr(pass * 32 + combo);
                #1;
                // R6: drive enables follow within the cycle
                exp_oe = {{(AW-SW){~line_oe_n}}, {SW{~sub_oe_n}}};
                check("R6 pin_oe", pin_oe, exp_oe);
                if (cyc_valid && sub_le)
                    exp_pin[SW-1:0] = cyc_addr[SW-1:0];
                if (cyc_valid && line_le)
                    exp_pin[AW-1:SW] = cyc_addr[AW-1:SW];
                exp_bs = cyc_valid && sub_le && line_le && !sub_oe_n && !line_oe_n;
                @(posedge clk); #1;
                if (!cyc_valid)
                    check("R5 pin_out", pin_out, exp_pin);
                else if (sub_le && line_le)
                    check("R2 R3 pin_out", pin_out, exp_pin);
                else if (sub_le)
                    check("R2 R4 pin_out", pin_out, exp_pin);
                else if (line_le)
                    check("R3 R4 pin_out", pin_out, exp_pin);
                else
                    check("R4 pin_out", pin_out, exp_pin);
                check("R7 bus_start", AW'(bus_start), AW'(exp_bs));
            end
        end

        // R7: strobe lasts one cycle only
        @(negedge clk);
        cyc_valid = 1'b1; sub_le = 1'b1; line_le = 1'b1;
        sub_oe_n = 1'b0; line_oe_n = 1'b0; cyc_addr = mk_addr(500);
        @(negedge clk);
        cyc_valid = 1'b0;
        check("R7 bus_start set", AW'(bus_start), AW'(1));
        @(posedge clk); #1;
        check("R7 bus_start clear", AW'(bus_start), '0);
        exp_pin = mk_addr(500);

        // R8/R9: snoop strobes under every output-enable combination
        for (int rep = 0; rep < 3; rep++) begin
            for (int oe = 0; oe < 4; oe++) begin
                @(negedge clk);
                sub_oe_n  = oe[0];
                line_oe_n = oe[1];
                snp_start = 1'b1;
                pin_in    = mk_addr(700 + rep * 4 + oe);
                @(posedge clk); #1;
                if (oe == 3) begin
                    exp_snp = mk_addr(700 + rep * 4 + oe);
                    check("R8 snp_addr", snp_addr, exp_snp);
                    check("R8 snp_err", AW'(snp_err), '0);
                end else begin
                    check("R9 snp_addr", snp_addr, exp_snp);
                    check("R9 snp_err", AW'(snp_err), AW'(1));
                end
                check("R4 pin_out under snoop", pin_out, exp_pin);
                @(negedge clk);
                snp_start = 1'b0;
                pin_in    = ~pin_in;
                @(posedge clk); #1;
                check("R9 snp_err quiet", AW'(snp_err), '0);
                check("R9 snp_addr idle", snp_addr, exp_snp);
            end
        end

        // R1: reset mid-run clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 pin_out again", pin_out, '0);
        check("R1 snp_addr again", snp_addr, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule